// File: doc/BRIEF.md
# Programmable-Length Sync Pattern Detector

This block watches a serial receive bit stream, one bit per cycle in which a valid strobe is high, and searches it for a synchronisation pattern. The pattern is taken from a 16-bit register input, and a 2-bit length code sets how much of it is used. The code selects one of four sync sources: a 4-bit pattern, an 8-bit pattern for single-character sync, a 16-bit pattern for double-character sync, or an external carrier-detect input that stands in for a stored pattern. One comparator serves all three pattern lengths because the unused upper bits are masked off.

While the detector is searching, it compares the most recent bits against the pattern on every valid bit. On a match it reports that the receiver is synchronised and starts to count character boundaries. From then on it assembles 8-bit characters, first-received bit in bit 0, and presents each finished character with a one-cycle strobe.

An optional stripping mode drops the sync characters that follow the lock until the first ordinary character arrives. A hunt command returns the detector to the search state at any time and discards any partial alignment.

Top module: `sync_hunt_detector`

## Requirements
- R1: After synchronous reset, synced, sync_hit and char_vld are all low.
- R2: With len_sel 01, 10 or 11, bits are shifted in first-received-first (LSB-first) and compared on every valid bit while searching. The first received bit of the pattern is compared with sync_pat bit 0. On the valid bit that completes a match, synced rises in the next cycle and sync_hit is high for exactly that one cycle.
- R3: Code 01 compares only sync_pat[3:0], code 10 only sync_pat[7:0], and code 11 all of sync_pat[15:0]. Unused upper pattern bits have no effect on locking.
- R4: No pattern lock happens until at least as many valid bits as the pattern length have arrived since reset or the last hunt command.
- R5: With len_sel 00, the detector locks on the first valid bit that arrives while carrier_det is high, and that bit is bit 0 of the first character. With codes 01, 10 and 11, carrier_det has no effect on locking.
- R6: With len_sel 00 and the detector locked, a valid bit that arrives while carrier_det is low returns the detector to the search state in the next cycle.
- R7: After a pattern lock, every 8 valid bits following the last pattern bit form a character. char_vld is high for one cycle, the cycle after the eighth bit, and char_data bit 0 holds the first bit received of that character.
- R8: A hunt command clears synced in the next cycle, discards any partial character, and restarts the bit count of R4.
- R9: When strip_en is high, characters equal to the sync character that directly follow a lock are not emitted. The sync character is the low nibble of sync_pat repeated twice for code 01, sync_pat[7:0] for code 10, and either sync_pat[7:0] or sync_pat[15:8] for code 11.
- R10: Stripping stops at the first character that is not a sync character, so later sync characters are emitted. When strip_en is low, every character is emitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | A receive bit is present this cycle |
| bit_in | input | 1 | Receive bit value |
| carrier_det | input | 1 | External carrier detect, used as the sync event with code 00 |
| len_sel | input | 2 | Sync source: 00 external, 01 4-bit, 10 8-bit, 11 16-bit |
| sync_pat | input | 16 | Sync pattern register contents |
| strip_en | input | 1 | Suppress repeated sync characters after a lock |
| hunt_cmd | input | 1 | Return to the search state and drop alignment |
| synced | output | 1 | Detector is locked |
| sync_hit | output | 1 | One-cycle pulse on each lock |
| char_vld | output | 1 | One-cycle strobe for a finished character |
| char_data | output | 8 | Finished character, first received bit in bit 0 |

## Verification
The bench uses the package defaults: a 16-bit search window and 8-bit characters. With these sizes every length code can be exercised in one run, including the 16-bit pattern whose two halves count as different sync characters during stripping. Each length is checked one bit short of the pattern and then on the completing bit. The pattern inputs carry non-zero upper bits, so a failure to mask them shows up as a missed lock. Characters are checked through an expected-value queue, so a misaligned boundary, a stripped character that should not be stripped, or a character that should not appear at all each cause a mismatch.

// File: rtl/syncdet_pkg.sv
package syncdet_pkg;

    localparam int SR_W   = 16;
    localparam int CHAR_W = 8;
    localparam int CNT_W  = $clog2(CHAR_W);
    localparam int FILL_W = $clog2(SR_W + 1);

    typedef enum logic [1:0] {
        LEN_EXT = 2'b00,
        LEN_4   = 2'b01,
        LEN_8   = 2'b10,
        LEN_16  = 2'b11
    } len_e;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } state_e;

    typedef struct packed {
        logic              vld;
        logic [CHAR_W-1:0] data;
    } char_t;

    // number of pattern bits used for a given length code
    function automatic logic [FILL_W-1:0] pat_len(len_e l);
        case (l)
            LEN_4:   return FILL_W'(4);
            LEN_8:   return FILL_W'(8);
            LEN_16:  return FILL_W'(16);
            default: return '0;
        endcase
    endfunction

    // mask selecting the compared low bits of the pattern
    function automatic logic [SR_W-1:0] pat_mask(len_e l);
        case (l)
            LEN_4:   return SR_W'(16'h000F);
            LEN_8:   return SR_W'(16'h00FF);
            LEN_16:  return SR_W'(16'hFFFF);
            default: return '0;
        endcase
    endfunction

    // newest bits of the window, aligned so the oldest lands in bit 0
    function automatic logic [SR_W-1:0] recent_bits(logic [SR_W-1:0] win, len_e l);
        case (l)
            LEN_4:   return SR_W'(win[SR_W-1 -: 4]);
            LEN_8:   return SR_W'(win[SR_W-1 -: 8]);
            LEN_16:  return win;
            default: return '0;
        endcase
    endfunction

    // does a finished character count as a sync character
    function automatic logic is_sync_char(logic [CHAR_W-1:0] c,
                                          logic [SR_W-1:0]   pat,
                                          len_e              l);
        case (l)
            LEN_4:   return c == {pat[3:0], pat[3:0]};
            LEN_8:   return c == pat[7:0];
            LEN_16:  return (c == pat[7:0]) || (c == pat[15:8]);
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sync_window.sv
module sync_window
    import syncdet_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            bit_vld,
    input  logic            bit_in,
    input  len_e            len,
    input  logic [SR_W-1:0] pat,
    output logic            hit
);

    logic [SR_W-1:0]   win_q;
    logic [SR_W-1:0]   win_d;
    logic [FILL_W-1:0] fill_q;
    logic [FILL_W-1:0] fill_d;
    logic              enough;
    logic              same;

    always_comb begin
        win_d  = {bit_in, win_q[SR_W-1:1]};
        fill_d = (fill_q == FILL_W'(SR_W)) ? fill_q : fill_q + 1'b1;
        enough = fill_d >= pat_len(len);
        same   = ((recent_bits(win_d, len) ^ pat) & pat_mask(len)) == '0;
        hit    = bit_vld && (len != LEN_EXT) && enough && same;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            win_q  <= '0;
            fill_q <= '0;
        end else if (bit_vld) begin
            win_q  <= win_d;
            fill_q <= fill_d;
        end
    end

endmodule

// File: rtl/sync_fsm.sv
module sync_fsm
    import syncdet_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   hunt_cmd,
    input  logic   bit_vld,
    input  logic   carrier_det,
    input  len_e   len,
    input  logic   hit,
    output state_e state_q,
    output logic   lock_evt,
    output logic   drop_evt,
    output logic   hit_pulse_q
);

    logic sync_src;

    always_comb begin
        sync_src = (len == LEN_EXT) ? carrier_det : hit;
        lock_evt = (state_q == ST_HUNT) && !hunt_cmd && bit_vld && sync_src;
        drop_evt = (state_q == ST_LOCK) && !hunt_cmd && bit_vld &&
                   (len == LEN_EXT) && !carrier_det;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_HUNT;
            hit_pulse_q <= 1'b0;
        end else begin
            hit_pulse_q <= lock_evt;
            if (hunt_cmd || drop_evt) begin
                state_q <= ST_HUNT;
            end else if (lock_evt) begin
                state_q <= ST_LOCK;
            end
        end
    end

endmodule

// File: rtl/char_asm.sv
module char_asm
    import syncdet_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            hunt_cmd,
    input  logic            bit_vld,
    input  logic            bit_in,
    input  len_e            len,
    input  logic [SR_W-1:0] pat,
    input  logic            strip_en,
    input  state_e          state_q,
    input  logic            lock_evt,
    input  logic            drop_evt,
    output char_t           out_q
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAR_W - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [CHAR_W-1:0] sh_q;
    logic [CHAR_W-1:0] sh_d;
    logic              lead_q;
    logic              locked;
    logic              suppress;

    always_comb begin
        sh_d     = {bit_in, sh_q[CHAR_W-1:1]};
        locked   = state_q == ST_LOCK;
        suppress = strip_en && lead_q && is_sync_char(sh_d, pat, len);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            sh_q   <= '0;
            lead_q <= 1'b1;
            out_q  <= '0;
        end else begin
            out_q.vld <= 1'b0;
            if (hunt_cmd || drop_evt) begin
                cnt_q  <= '0;
                lead_q <= 1'b1;
            end else if (lock_evt) begin
                lead_q <= 1'b1;
                if (len == LEN_EXT) begin
                    // the carrier-qualified bit opens the first character
                    cnt_q <= CNT_W'(1);
                    sh_q  <= sh_d;
                end else begin
                    cnt_q <= '0;
                end
            end else if (locked && bit_vld) begin
                sh_q <= sh_d;
                if (cnt_q == LAST) begin
                    cnt_q <= '0;
                    if (!suppress) begin
                        out_q.vld  <= 1'b1;
                        out_q.data <= sh_d;
                        lead_q     <= 1'b0;
                    end
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sync_hunt_detector.sv
module sync_hunt_detector
    import syncdet_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  logic              carrier_det,
    input  logic [1:0]        len_sel,
    input  logic [SR_W-1:0]   sync_pat,
    input  logic              strip_en,
    input  logic              hunt_cmd,
    output logic              synced,
    output logic              sync_hit,
    output logic              char_vld,
    output logic [CHAR_W-1:0] char_data
);

    len_e   len;
    logic   hit;
    state_e state_q;
    logic   lock_evt;
    logic   drop_evt;
    char_t  chr;

    assign len = len_e'(len_sel);

    sync_window u_window (
        .clk     (clk),
        .rst     (rst),
        .clr     (hunt_cmd),
        .bit_vld (bit_vld),
        .bit_in  (bit_in),
        .len     (len),
        .pat     (sync_pat),
        .hit     (hit)
    );

    sync_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .hunt_cmd    (hunt_cmd),
        .bit_vld     (bit_vld),
        .carrier_det (carrier_det),
        .len         (len),
        .hit         (hit),
        .state_q     (state_q),
        .lock_evt    (lock_evt),
        .drop_evt    (drop_evt),
        .hit_pulse_q (sync_hit)
    );

    char_asm u_chars (
        .clk      (clk),
        .rst      (rst),
        .hunt_cmd (hunt_cmd),
        .bit_vld  (bit_vld),
        .bit_in   (bit_in),
        .len      (len),
        .pat      (sync_pat),
        .strip_en (strip_en),
        .state_q  (state_q),
        .lock_evt (lock_evt),
        .drop_evt (drop_evt),
        .out_q    (chr)
    );

    assign synced    = state_q == ST_LOCK;
    assign char_vld  = chr.vld;
    assign char_data = chr.data;

endmodule

// File: rtl/sync_hunt_detector_chk.sv
module sync_hunt_detector_chk (
    input logic       clk,
    input logic       rst,
    input logic       bit_vld,
    input logic       carrier_det,
    input logic [1:0] len_sel,
    input logic       hunt_cmd,
    input logic       synced,
    input logic       sync_hit,
    input logic       char_vld
);

    AST_HUNT_DROPS_LOCK: assert property (@(posedge clk) disable iff (rst)
        hunt_cmd |=> !synced && !char_vld); // R8

    AST_CHAR_AFTER_LOCKED_BIT: assert property (@(posedge clk) disable iff (rst)
        char_vld |-> $past(synced) && $past(bit_vld)); // R7

    AST_HIT_ONLY_FROM_HUNT: assert property (@(posedge clk) disable iff (rst)
        sync_hit |-> synced && !$past(synced)); // R2

    AST_HIT_NEEDS_BIT: assert property (@(posedge clk) disable iff (rst)
        sync_hit |-> $past(bit_vld) && !$past(hunt_cmd)); // R2

    AST_HIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sync_hit |=> !sync_hit); // R2

    AST_CARRIER_LOSS: assert property (@(posedge clk) disable iff (rst)
        (len_sel == 2'b00 && synced && bit_vld && !carrier_det && !hunt_cmd) |=> !synced); // R6

    AST_EXT_LOCK_CARRIER: assert property (@(posedge clk) disable iff (rst)
        (sync_hit && $past(len_sel) == 2'b00) |-> $past(carrier_det)); // R5

endmodule

bind sync_hunt_detector sync_hunt_detector_chk chk_i (.*);

// File: tb/sync_hunt_detector_tb_top.sv
module sync_hunt_detector_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        bit_vld;
    logic        bit_in;
    logic        carrier_det;
    logic [1:0]  len_sel;
    logic [15:0] sync_pat;
    logic        strip_en;
    logic        hunt_cmd;
    logic        synced;
    logic        sync_hit;
    logic        char_vld;
    logic [7:0]  char_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    sync_hunt_detector dut_i (
        .clk         (clk),
        .rst         (rst),
        .bit_vld     (bit_vld),
        .bit_in      (bit_in),
        .carrier_det (carrier_det),
        .len_sel     (len_sel),
        .sync_pat    (sync_pat),
        .strip_en    (strip_en),
        .hunt_cmd    (hunt_cmd),
        .synced      (synced),
        .sync_hit    (sync_hit),
        .char_vld    (char_vld),
        .char_data   (char_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put_bit(input logic b);
        @(negedge clk);
        bit_vld  = 1'b1;
        bit_in   = b;
        hunt_cmd = 1'b0;
    endtask

    task automatic put_bits(input logic [15:0] v, input int n);
        for (int i = 0; i < n; i++) put_bit(v[i]);
    endtask

    task automatic put_byte(input logic [7:0] b);
        put_bits({8'h00, b}, 8);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            bit_vld  = 1'b0;
            hunt_cmd = 1'b0;
        end
    endtask

    task automatic do_hunt();
        @(negedge clk);
        bit_vld  = 1'b0;
        hunt_cmd = 1'b1;
        @(negedge clk);
        hunt_cmd = 1'b0;
    endtask

    task automatic expect_char(input logic [7:0] b);
        exp_q.push_back(b);
    endtask

    // monitor: every finished character is popped from the scoreboard
    always @(negedge clk) begin
        if (!rst && char_vld) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R7/R9/R10: unexpected character actual %0h expected none", char_data);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (char_data !== e) begin
                    n_fail++;
                    $display("FAIL R7/R9/R10: character actual %0h expected %0h", char_data, e);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bit_vld = 1'b0; bit_in = 1'b0; carrier_det = 1'b0;
        len_sel = 2'b10; sync_pat = 16'h127E; strip_en = 1'b0; hunt_cmd = 1'b0;
        idle(3);
        rst = 1'b0;
        idle(1);
        check("R1 synced", synced, 0);
        check("R1 sync_hit", sync_hit, 0);
        check("R1 char_vld", char_vld, 0);

        // 8-bit pattern 0x7E, upper pattern bits non-zero (R2, R3, R7)
        do_hunt();
        put_bit(0); put_bit(0); put_bit(1); put_bit(0);
        put_bits(16'h007E, 7);
        idle(1);
        check("R2 no lock before last bit", synced, 0);
        put_bit(0);
        idle(1);
        check("R2 lock 8-bit", synced, 1);
        check("R2 sync_hit pulse", sync_hit, 1);
        idle(1);
        check("R2 sync_hit one cycle", sync_hit, 0);
        expect_char(8'h55); expect_char(8'hA3);
        put_byte(8'h55); put_byte(8'hA3);
        idle(2);

        // 4-bit all-zero pattern with garbage above: fill count (R4, R3)
        len_sel = 2'b01; sync_pat = 16'hABC0;
        do_hunt();
        check("R8 hunt clears synced", synced, 0);
        put_bits(16'h0000, 3);
        idle(1);
        check("R4 no lock before 4 bits", synced, 0);
        put_bit(0);
        idle(1);
        check("R3 lock on masked 4-bit", synced, 1);

        // 16-bit pattern with stripping of either half (R2, R9, R10)
        len_sel = 2'b11; sync_pat = 16'hB1C4; strip_en = 1'b1;
        do_hunt();
        put_bits(16'hB1C4, 15);
        idle(1);
        check("R4 16-bit not yet", synced, 0);
        put_bit(1);
        idle(1);
        check("R2 lock 16-bit", synced, 1);
        expect_char(8'h99); expect_char(8'hC4);
        put_byte(8'hC4); put_byte(8'hB1); put_byte(8'h99); put_byte(8'hC4);
        idle(2);
        check("R9 16-bit strip drained", exp_q.size(), 0);

        // 4-bit stripping: sync char is nibble doubled (R9)
        len_sel = 2'b01; sync_pat = 16'h000A;
        do_hunt();
        put_bits(16'h000A, 4);
        idle(1);
        check("R2 lock 4-bit", synced, 1);
        expect_char(8'h3C);
        put_byte(8'hAA); put_byte(8'h3C);
        idle(2);
        check("R9 4-bit strip drained", exp_q.size(), 0);

        // stripping disabled: sync chars are emitted (R10)
        len_sel = 2'b10; sync_pat = 16'h127E; strip_en = 1'b0;
        do_hunt();
        put_bits(16'h007E, 8);
        idle(1);
        check("R2 relock 8-bit", synced, 1);
        expect_char(8'h7E); expect_char(8'h7E);
        put_byte(8'h7E); put_byte(8'h7E);
        idle(2);
        check("R10 no strip drained", exp_q.size(), 0);

        // external carrier detect (R5, R6)
        len_sel = 2'b00;
        do_hunt();
        carrier_det = 1'b0;
        put_bit(1);
        idle(1);
        check("R5 no lock without carrier", synced, 0);
        carrier_det = 1'b1;
        expect_char(8'h3C);
        put_byte(8'h3C);
        idle(1);
        check("R5 lock on carrier", synced, 1);
        carrier_det = 1'b0;
        put_bit(1);
        idle(2);
        check("R6 carrier loss", synced, 0);
        check("R5 carrier char drained", exp_q.size(), 0);

        // carrier ignored in pattern mode (R5)
        len_sel = 2'b10; carrier_det = 1'b1;
        do_hunt();
        put_byte(8'h00);
        idle(1);
        check("R5 carrier ignored in 8-bit", synced, 0);
        carrier_det = 1'b0;

        // hunt mid-character drops the partial character (R8)
        put_bits(16'h007E, 8);
        idle(1);
        check("R2 lock before hunt", synced, 1);
        put_bits(16'h000F, 4);
        do_hunt();
        check("R8 hunt while locked", synced, 0);
        put_bits(16'h007E, 8);
        idle(1);
        check("R8 relock after hunt", synced, 1);
        expect_char(8'h5A);
        put_byte(8'h5A);
        idle(3);
        check("R8 realigned char drained", exp_q.size(), 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule